// File: doc/BRIEF.md
# Smart Card Slot Control Register Bank

This block holds the write-side control registers for a set of smart card slots. Two slots are built by default. Each slot has one 8-bit control register at its own address. A register write reaches the bank through a plain port carrying an address, data and a write strobe. A write to a slot register is checked against that slot's live status before it takes effect. The status inputs are supply fault, protection fault, card presence and mute. The block also checks the write against the register's own current contents and against the other slots' I/O enables.

Accepted writes produce one-clock request pulses for the sequencer that sits outside the block. There are three kinds:

- an activation request, which carries a cold reset;
- a deactivation request;
- a warm reset request.

The block also drives these steady per-slot controls:

- a supply voltage code;
- a clock source select;
- a 2-bit sub-register selector;
- the I/O enable;
- the active state;
- the pending warm reset state.

Only one slot can have its I/O enabled at a time. A write that breaks this rule is refused and sets a sticky error flag.

Top module: `cardslot_ctl_bank`

## Requirements
- R1: Slot s (counting from 0) is written when `wr_en` is 1 and `wr_addr` equals 01h + s. With the defaults, the first slot is at 01h and the second at 02h. A write to any other address changes no output.
- R2: In a slot register, bits 5:4 appear on that slot's `bank_sel` pair. Bit 3 appears on `clk_pd_sel`, where 1 selects the power-down clock setting and 0 selects the divider setting. Both fields can be written at any time.
- R3: Each slot's `vcc_sel` pair carries the supply code. The code is 2 (1.8 V) when bit 7 is 1, whatever bit 2 holds. When bit 7 is 0, the code is 1 (5 V) if bit 2 is 1 and 0 (3 V) if bit 2 is 0.
- R4: A write to a slot leaves bit 7 (the 1.8 V select) unchanged while that slot is active.
- R5: Writing bit 0 as 1 to an inactive slot activates it, but only when its supply fault is 0, its protection fault is 0 and card present is 1. The slot's `slot_active` bit then becomes 1 and `act_req` pulses.
- R6: A bit-0 write of 1 that fails any of the R5 conditions is refused. `slot_active` stays 0 and no `act_req` pulse is issued.
- R7: Writing bit 0 as 0 to an active slot clears `slot_active` and pulses `deact_req`.
- R8: Writing bit 1 as 1 sets `warm_pending` and pulses `warm_req`. Writing it as 0 clears `warm_pending`.
- R9: `warm_pending` is forced to 0 in any cycle where the slot's `mute` is 1 or its activation state changes (R5 or R7). This clear takes priority over a bit-1 write of 1 in the same cycle, and no `warm_req` pulse is then issued.
- R10: Bit 6 sets `io_en` for its slot. A write of bit 6 as 1 is refused while another slot's `io_en` is 1, so at most one `io_en` bit is ever 1. Writing bit 6 as 0 always clears it.
- R11: A refused I/O enable sets the sticky `io_err`. `io_err_clr` clears it, but a new refusal in the same cycle takes priority over the clear.
- R12: A synchronous active-high `rst` sets every output to 0.
- R13: Each request pulse lasts exactly one clock. It appears in the cycle after the accepted write, and the register outputs update in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| supply_fault | input | 2 | Per-slot supply fault |
| prot_fault | input | 2 | Per-slot protection fault |
| card_present | input | 2 | Per-slot card presence |
| mute | input | 2 | Per-slot mute, clears a pending warm reset |
| io_err_clr | input | 1 | Clears the I/O conflict flag |
| act_req | output | 2 | Activation with cold reset request pulse |
| deact_req | output | 2 | Deactivation request pulse |
| warm_req | output | 2 | Warm reset request pulse |
| vcc_sel | output | 4 | Supply code, 2 bits per slot (0 = 3 V, 1 = 5 V, 2 = 1.8 V) |
| clk_pd_sel | output | 2 | Clock source select per slot |
| io_en | output | 2 | I/O line enable per slot |
| bank_sel | output | 4 | Sub-register selector, 2 bits per slot |
| slot_active | output | 2 | Slot activated state |
| warm_pending | output | 2 | Warm reset bit per slot |
| io_err | output | 1 | Sticky I/O conflict flag |

## Verification
The properties assume the following about the inputs:
- `rst` is high from time zero until the first edges have passed.
- Every input changes only between clock edges.
- At most one address is presented per write.

The bench drives all inputs on the falling edge and holds each write for exactly one cycle. It changes the status inputs only between writes, so each refusal case (no card, supply fault, protection fault) is checked on its own. Mute is raised only in idle cycles, except in one deliberate case where it coincides with a warm reset write to show that the clear wins.

// File: rtl/cardslot_pkg.sv
package cardslot_pkg;
   localparam int REG_W     = 8;
   localparam int VCC_W     = 2;
   localparam int BANK_W    = 2;
   // field positions inside a slot control register
   localparam int F_LOW_V   = 7;
   localparam int F_IO      = 6;
   localparam int F_BANK_LO = 4;
   localparam int F_CLKSRC  = 3;
   localparam int F_HI_V    = 2;
   localparam int F_WARM    = 1;
   localparam int F_ACT     = 0;

   typedef enum logic [VCC_W-1:0] {
      VCC_3V0 = 2'd0,
      VCC_5V0 = 2'd1,
      VCC_1V8 = 2'd2
   } vcc_code_e;
endpackage

// File: rtl/cardslot_vcc_dec.sv
module cardslot_vcc_dec
   import cardslot_pkg::*;
(
   input  logic             low_v,
   input  logic             hi_v,
   output logic [VCC_W-1:0] code
);
   vcc_code_e sel;

   always_comb begin
      if (low_v)     sel = VCC_1V8;
      else if (hi_v) sel = VCC_5V0;
      else           sel = VCC_3V0;
   end

   assign code = sel;
endmodule

// File: rtl/cardslot_io_guard.sv
module cardslot_io_guard #(
   parameter int NUM_SLOTS = 2
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [NUM_SLOTS-1:0] io_en,
   input  logic [NUM_SLOTS-1:0] conflict,
   input  logic                 err_clr,
   output logic [NUM_SLOTS-1:0] others_on,
   output logic                 io_err
);
   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_other
      localparam logic [NUM_SLOTS-1:0] SELF = NUM_SLOTS'(1) << s;
      assign others_on[s] = |(io_en & ~SELF);
   end

   always_ff @(posedge clk) begin
      if (rst)            io_err <= 1'b0;
      else if (|conflict) io_err <= 1'b1;
      else if (err_clr)   io_err <= 1'b0;
   end
endmodule

// File: rtl/cardslot_slot_reg.sv
module cardslot_slot_reg
   import cardslot_pkg::*;
(
   input  logic              clk,
   input  logic              rst,
   input  logic              hit,
   input  logic [REG_W-1:0]  wdata,
   input  logic              sup_fault,
   input  logic              prt_fault,
   input  logic              present,
   input  logic              mute,
   input  logic              others_on,
   output logic              act_pulse,
   output logic              deact_pulse,
   output logic              warm_pulse,
   output logic              low_v,
   output logic              hi_v,
   output logic              clk_src,
   output logic [BANK_W-1:0] bank,
   output logic              io_on,
   output logic              active,
   output logic              warm,
   output logic              conflict
);
   logic act_ok, deact_ok, act_evt, warm_clr, warm_set;

   assign act_ok   = hit && wdata[F_ACT] && !active && !sup_fault && !prt_fault && present;
   assign deact_ok = hit && !wdata[F_ACT] && active;
   assign act_evt  = act_ok || deact_ok;
   assign warm_clr = mute || act_evt;
   assign warm_set = hit && wdata[F_WARM] && !warm_clr;
   assign conflict = hit && wdata[F_IO] && others_on;

   always_ff @(posedge clk) begin
      if (rst) begin
         act_pulse   <= 1'b0;
         deact_pulse <= 1'b0;
         warm_pulse  <= 1'b0;
         low_v       <= 1'b0;
         hi_v        <= 1'b0;
         clk_src     <= 1'b0;
         bank        <= '0;
         io_on       <= 1'b0;
         active      <= 1'b0;
         warm        <= 1'b0;
      end else begin
         act_pulse   <= act_ok;
         deact_pulse <= deact_ok;
         warm_pulse  <= warm_set;
         if (act_ok)        active <= 1'b1;
         else if (deact_ok) active <= 1'b0;
         if (warm_clr) warm <= 1'b0;
         else if (hit) warm <= wdata[F_WARM];
         if (hit) begin
            if (!active) low_v <= wdata[F_LOW_V];
            hi_v    <= wdata[F_HI_V];
            clk_src <= wdata[F_CLKSRC];
            bank    <= wdata[F_BANK_LO +: BANK_W];
            io_on   <= wdata[F_IO] && !others_on;
         end
      end
   end
endmodule

// File: rtl/cardslot_ctl_bank.sv
module cardslot_ctl_bank
   import cardslot_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 1
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [REG_W-1:0]            wr_data,
   input  logic [NUM_SLOTS-1:0]        supply_fault,
   input  logic [NUM_SLOTS-1:0]        prot_fault,
   input  logic [NUM_SLOTS-1:0]        card_present,
   input  logic [NUM_SLOTS-1:0]        mute,
   input  logic                        io_err_clr,
   output logic [NUM_SLOTS-1:0]        act_req,
   output logic [NUM_SLOTS-1:0]        deact_req,
   output logic [NUM_SLOTS-1:0]        warm_req,
   output logic [NUM_SLOTS*VCC_W-1:0]  vcc_sel,
   output logic [NUM_SLOTS-1:0]        clk_pd_sel,
   output logic [NUM_SLOTS-1:0]        io_en,
   output logic [NUM_SLOTS*BANK_W-1:0] bank_sel,
   output logic [NUM_SLOTS-1:0]        slot_active,
   output logic [NUM_SLOTS-1:0]        warm_pending,
   output logic                        io_err
);
   localparam int LAST_ADDR = BASE_ADDR + NUM_SLOTS - 1;

   initial begin
      if (NUM_SLOTS < 1)
         $fatal(1, "cardslot_ctl_bank: NUM_SLOTS must be at least 1");
      if (BASE_ADDR < 0 || LAST_ADDR >= (1 << ADDR_W))
         $fatal(1, "cardslot_ctl_bank: slot addresses do not fit ADDR_W");
   end

   logic [NUM_SLOTS-1:0] others_on;
   logic [NUM_SLOTS-1:0] conflict;
   logic [NUM_SLOTS-1:0] low_v;
   logic [NUM_SLOTS-1:0] hi_v;

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(BASE_ADDR + s);
      logic hit;
      assign hit = wr_en && (wr_addr == MY_ADDR);

      cardslot_slot_reg u_reg (
         .clk         (clk),
         .rst         (rst),
         .hit         (hit),
         .wdata       (wr_data),
         .sup_fault   (supply_fault[s]),
         .prt_fault   (prot_fault[s]),
         .present     (card_present[s]),
         .mute        (mute[s]),
         .others_on   (others_on[s]),
         .act_pulse   (act_req[s]),
         .deact_pulse (deact_req[s]),
         .warm_pulse  (warm_req[s]),
         .low_v       (low_v[s]),
         .hi_v        (hi_v[s]),
         .clk_src     (clk_pd_sel[s]),
         .bank        (bank_sel[s*BANK_W +: BANK_W]),
         .io_on       (io_en[s]),
         .active      (slot_active[s]),
         .warm        (warm_pending[s]),
         .conflict    (conflict[s])
      );

      cardslot_vcc_dec u_vcc (
         .low_v (low_v[s]),
         .hi_v  (hi_v[s]),
         .code  (vcc_sel[s*VCC_W +: VCC_W])
      );
   end

   cardslot_io_guard #(.NUM_SLOTS(NUM_SLOTS)) u_guard (
      .clk       (clk),
      .rst       (rst),
      .io_en     (io_en),
      .conflict  (conflict),
      .err_clr   (io_err_clr),
      .others_on (others_on),
      .io_err    (io_err)
   );
endmodule

// File: rtl/cardslot_ctl_bank_chk.sv
module cardslot_ctl_bank_chk
   import cardslot_pkg::*;
#(
   parameter int NUM_SLOTS = 2,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 1
) (
   input logic                        clk,
   input logic                        rst,
   input logic                        wr_en,
   input logic [ADDR_W-1:0]           wr_addr,
   input logic [REG_W-1:0]            wr_data,
   input logic [NUM_SLOTS-1:0]        supply_fault,
   input logic [NUM_SLOTS-1:0]        prot_fault,
   input logic [NUM_SLOTS-1:0]        card_present,
   input logic [NUM_SLOTS-1:0]        mute,
   input logic                        io_err_clr,
   input logic [NUM_SLOTS-1:0]        act_req,
   input logic [NUM_SLOTS-1:0]        deact_req,
   input logic [NUM_SLOTS-1:0]        warm_req,
   input logic [NUM_SLOTS*VCC_W-1:0]  vcc_sel,
   input logic [NUM_SLOTS-1:0]        clk_pd_sel,
   input logic [NUM_SLOTS-1:0]        io_en,
   input logic [NUM_SLOTS*BANK_W-1:0] bank_sel,
   input logic [NUM_SLOTS-1:0]        slot_active,
   input logic [NUM_SLOTS-1:0]        warm_pending,
   input logic                        io_err
);
   assert_io_onehot_R10: assert property (@(posedge clk) disable iff (rst)
      $onehot0(io_en));

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_chk
      logic hit, bad_status;
      assign hit        = wr_en && (wr_addr == ADDR_W'(BASE_ADDR + s));
      assign bad_status = supply_fault[s] || prot_fault[s] || !card_present[s];

      assert_act_sets_active_R5: assert property (@(posedge clk) disable iff (rst)
         act_req[s] |-> slot_active[s]);

      assert_refused_start_R6: assert property (@(posedge clk) disable iff (rst)
         (hit && wr_data[F_ACT] && !slot_active[s] && bad_status)
            |=> (!act_req[s] && !slot_active[s]));

      assert_deact_clears_R7: assert property (@(posedge clk) disable iff (rst)
         deact_req[s] |-> !slot_active[s]);

      assert_low_v_locked_R4: assert property (@(posedge clk) disable iff (rst)
         (hit && slot_active[s])
            |=> ((vcc_sel[s*VCC_W +: VCC_W] == VCC_1V8)
                 == $past(vcc_sel[s*VCC_W +: VCC_W] == VCC_1V8)));

      assert_mute_clears_warm_R9: assert property (@(posedge clk) disable iff (rst)
         mute[s] |=> (!warm_pending[s] && !warm_req[s]));

      assert_act_single_R13: assert property (@(posedge clk) disable iff (rst)
         act_req[s] |=> !act_req[s]);

      assert_warm_single_R13: assert property (@(posedge clk) disable iff (rst)
         warm_req[s] |=> (!warm_req[s] || $past(hit && wr_data[F_WARM])));
   end
endmodule

bind cardslot_ctl_bank cardslot_ctl_bank_chk #(
   .NUM_SLOTS (NUM_SLOTS),
   .ADDR_W    (ADDR_W),
   .BASE_ADDR (BASE_ADDR)
) u_chk (.*);

// File: tb/cardslot_ctl_bank_tb.sv
module cardslot_ctl_bank_tb;
   localparam int N  = 2;
   localparam int OW = 23;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         wr_en = 1'b0;
   logic [7:0]   wr_addr = '0;
   logic [7:0]   wr_data = '0;
   logic [N-1:0] supply_fault = '0, prot_fault = '0, card_present = '1, mute = '0;
   logic         io_err_clr = 1'b0;
   logic [N-1:0] act_req, deact_req, warm_req, clk_pd_sel, io_en, slot_active, warm_pending;
   logic [2*N-1:0] vcc_sel, bank_sel;
   logic         io_err;

   always #2 clk = ~clk;

   cardslot_ctl_bank u_dut (.*);

   typedef struct {
      logic [OW-1:0] v;
      string         tag;
   } item_t;
   item_t q[$];

   int total = 0, bad = 0;
   bit done = 1'b0;

   // bench model of the register state
   bit m_lowv[N], m_hiv[N], m_clk[N], m_io[N], m_act[N], m_warm[N];
   bit [1:0] m_bank[N];
   bit m_err;
   bit [N-1:0] p_act, p_deact, p_warm;

   function automatic logic [OW-1:0] pack_exp();
      logic [N-1:0] ck, io, ac, wp;
      logic [2*N-1:0] vc, bk;
      for (int s = 0; s < N; s++) begin
         ck[s] = m_clk[s]; io[s] = m_io[s]; ac[s] = m_act[s]; wp[s] = m_warm[s];
         vc[2*s +: 2] = m_lowv[s] ? 2'd2 : (m_hiv[s] ? 2'd1 : 2'd0);
         bk[2*s +: 2] = m_bank[s];
      end
      return {p_act, p_deact, p_warm, vc, ck, io, bk, ac, wp, m_err};
   endfunction

   // driver: called at a falling edge, returns at the next falling edge
   task automatic step(input bit wr, input logic [7:0] a, input logic [7:0] d, input string tag);
      item_t it;
      bit conf;
      wr_en = wr; wr_addr = a; wr_data = d;
      p_act = '0; p_deact = '0; p_warm = '0; conf = 1'b0;
      if (rst) begin
         for (int s = 0; s < N; s++) begin
            m_lowv[s] = 0; m_hiv[s] = 0; m_clk[s] = 0; m_io[s] = 0;
            m_act[s] = 0; m_warm[s] = 0; m_bank[s] = 0;
         end
         m_err = 0;
      end else begin
         bit [N-1:0] io_now;
         for (int s = 0; s < N; s++) io_now[s] = m_io[s];
         for (int s = 0; s < N; s++) begin
            bit hit, evt, others;
            hit = wr && (a == 8'(1 + s));
            others = |(io_now & ~(N'(1) << s));
            evt = 1'b0;
            if (hit && d[0] && !m_act[s] && !supply_fault[s] && !prot_fault[s] && card_present[s]) begin
               m_act[s] = 1; p_act[s] = 1; evt = 1;
            end else if (hit && !d[0] && m_act[s]) begin
               m_act[s] = 0; p_deact[s] = 1; evt = 1;
            end
            if (mute[s] || evt) m_warm[s] = 0;
            else if (hit) begin
               m_warm[s] = d[1]; p_warm[s] = d[1];
            end
            if (hit) begin
               if (!(m_act[s] && !evt) && !(evt && !m_act[s]) ) m_lowv[s] = d[7];
               m_hiv[s] = d[2]; m_clk[s] = d[3]; m_bank[s] = d[5:4];
               if (d[6] && others) conf = 1;
               m_io[s] = d[6] && !others;
            end
         end
         if (conf) m_err = 1;
         else if (io_err_clr) m_err = 0;
      end
      @(posedge clk);
      it.v = pack_exp(); it.tag = tag;
      q.push_back(it);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic idle(input string tag);
      step(1'b0, 8'h00, 8'h00, tag);
   endtask

   // monitor
   always @(negedge clk) begin
      if (q.size() > 0) begin
         item_t it;
         logic [OW-1:0] act;
         it = q.pop_front();
         act = {act_req, deact_req, warm_req, vcc_sel, clk_pd_sel, io_en, bank_sel,
                slot_active, warm_pending, io_err};
         total++;
         if (act !== it.v) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.v);
         end
      end
   end

   initial begin
      #400000;
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      idle("R12 reset");
      idle("R12 reset held");
      rst = 1'b0;
      idle("R12 idle after reset");
      // supply codes and plain fields
      step(1, 8'h01, 8'h04, "R3 5V code");
      step(1, 8'h01, 8'h84, "R3 1V8 overrides 5V");
      step(1, 8'h01, 8'h00, "R3 3V code");
      step(1, 8'h02, 8'h38, "R2 bank and clock select slot2");
      step(1, 8'h01, 8'h14, "R2 bank slot1");
      step(1, 8'h03, 8'hFF, "R1 unmapped address ignored");
      step(1, 8'h00, 8'hFF, "R1 address 0 ignored");
      // activation refusals
      card_present[0] = 1'b0;
      step(1, 8'h01, 8'h01, "R6 refused no card");
      card_present[0] = 1'b1; supply_fault[0] = 1'b1;
      step(1, 8'h01, 8'h01, "R6 refused supply fault");
      supply_fault[0] = 1'b0; prot_fault[0] = 1'b1;
      step(1, 8'h01, 8'h01, "R6 refused protection fault");
      prot_fault[0] = 1'b0;
      step(1, 8'h01, 8'h01, "R5 activation accepted");
      idle("R13 activation pulse ends");
      step(1, 8'h01, 8'h85, "R4 1V8 locked while active");
      step(1, 8'h01, 8'h09, "R2 clock select while active");
      step(1, 8'h01, 8'h00, "R7 deactivation");
      idle("R13 deactivation pulse ends");
      step(1, 8'h01, 8'h80, "R4 1V8 writable when inactive");
      // warm reset
      step(1, 8'h02, 8'h02, "R8 warm request");
      idle("R13 warm pulse ends");
      mute[1] = 1'b1;
      idle("R9 mute clears warm");
      step(1, 8'h02, 8'h02, "R9 mute beats warm write");
      mute[1] = 1'b0;
      step(1, 8'h02, 8'h02, "R8 warm again");
      step(1, 8'h02, 8'h03, "R9 start event clears warm");
      step(1, 8'h02, 8'h03, "R8 warm write while active");
      step(1, 8'h02, 8'h00, "R8 warm written 0 with deactivation");
      // I/O exclusivity
      step(1, 8'h01, 8'h40, "R10 enable slot1 io");
      step(1, 8'h02, 8'h40, "R10 second io refused");
      io_err_clr = 1'b1;
      step(1, 8'h02, 8'h40, "R11 refusal beats clear");
      idle("R11 clear");
      io_err_clr = 1'b0;
      step(1, 8'h01, 8'h00, "R10 disable slot1 io");
      step(1, 8'h02, 8'h40, "R10 enable slot2 io");
      rst = 1'b1;
      idle("R12 reset clears all");
      rst = 1'b0;
      idle("R12 stays cleared");
      @(negedge clk);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule